// File: doc/BRIEF.md
# High-Speed Serial Transmitter with Low-Water Interrupt

This block is the sending half of a fast asynchronous serial port with a fixed 8N1 frame. A host writes bytes into a 64-entry queue. The block takes them out one at a time and shifts them onto a single output line. The length of one bit on the line is set by an 8-bit divider multiplied by a fixed oversampling factor of 14. The block always reports how many bytes are still waiting in the queue.

A latched status flag tells the host when the queue has drained down to a chosen low-water mark, so that software can refill it in bursts. The host clears the flag with a one-cycle strobe. A separate enable decides whether the flag drives the interrupt output. The host can also hold the line low to send a break. A clear-to-send input, with selectable polarity, can hold back new frames; a frame that has already started always runs to its end.

Top module: `hs_uart_tx`

## Requirements
- R1: A cycle with `wrEn` high stores `wrData` at the tail of a 64-byte queue when the queue is not full. `txLevel` reports the number of queued bytes. A byte moved into the shifter no longer counts.
- R2: A write while `txLevel` is 64 is dropped. The level stays at 64 and the dropped byte never appears on the line.
- R3: The line idles high. Each frame has a low start bit, then the 8 data bits least significant bit first, then a high stop bit. Every bit lasts `(divider+1)*14` clock cycles. Bytes leave in the order they were written.
- R4: `txTrig` codes 0, 1, 2 and 3 select low-water marks of 0, 4, 8 and 16 bytes. `irqStatus` becomes set in the cycle a byte leaves the queue if the occupancy just after that departure is at or below the mark. A write in that same cycle is not counted.
- R5: A one-cycle pulse on `irqClr` clears `irqStatus`. If a new set event falls in the same cycle, the set wins.
- R6: `irqOut` is high exactly when `irqStatus` is set and `irqEn` is high.
- R7: While `breakEn` is high, `txd` is low. No new frame starts, and queued bytes stay queued and are sent unchanged after the break ends.
- R8: With `ctsEnable` high, a new frame starts only while the clear-to-send input is active. It is active when `ctsIn` is 1 with `ctsInvert` 0, and when `ctsIn` is 0 with `ctsInvert` 1. A frame already on the line completes when the input goes inactive.
- R9: After reset, `txd` is high, `txLevel` is 0, and `irqStatus` and `irqOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the data port |
| wrData | input | 8 | Byte to queue |
| divider | input | 8 | Bit-period divider; one bit is (divider+1)*14 clocks |
| txTrig | input | 2 | Low-water mark select code |
| irqEn | input | 1 | Lets the status flag drive irqOut |
| irqClr | input | 1 | Clear strobe for the status flag |
| breakEn | input | 1 | Holds the line low as a break |
| ctsEnable | input | 1 | Turns on clear-to-send gating |
| ctsInvert | input | 1 | Inverts the clear-to-send polarity |
| ctsIn | input | 1 | Clear-to-send input (asynchronous) |
| txd | output | 1 | Serial output line |
| txLevel | output | 8 | Number of queued bytes |
| irqStatus | output | 1 | Latched low-water flag |
| irqOut | output | 1 | Interrupt request |

## Verification
The serial line is decoded by a bench receiver that samples at mid-bit. This receiver is run with random bytes at several divider values, so a wrong bit period, bit order or frame shape shows up as wrong bytes. A full queue of 64 random bytes followed by one extra write tells a correct overflow drop apart from an overwrite or a pointer slip. For every low-water code, the flag is watched at the departure that leaves the queue one byte above the mark and at the departure that reaches the mark. This separates an off-by-one threshold from a correct one. Break, clear-to-send polarity and a clear-to-send drop in the middle of a frame are driven as directed cases. Each shows whether a frame is held back, cut short or corrupted.

// File: rtl/hs_uart_tx_pkg.sv
package hs_uart_tx_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic load;   // take the queue head into the shifter
    logic shift;  // advance the shifter by one bit
  } txStrobes_t;

  // Low-water mark for a trigger code.
  function automatic int markOf(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/hs_uart_tx_datapath.sv
module hs_uart_tx_datapath
  import hs_uart_tx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int FRAME_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobes_t        strobes,
  output logic [CNT_W-1:0]  count,
  output logic              fifoEmpty,
  output logic              lineBit
);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [AW-1:0]      wrPtr;
  logic [AW-1:0]      rdPtr;
  logic [FRAME_W-1:0] shReg;
  logic               push;
  logic               pop;

  assign push      = wrEn && (count < CNT_W'(DEPTH));
  assign pop       = strobes.load && (count != '0);
  assign fifoEmpty = (count == '0);
  assign lineBit   = shReg[0];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Shifter: stop, data, start; ones fill in behind so the line rests high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '1;
    end else if (pop) begin
      shReg <= {1'b1, mem[rdPtr], 1'b0};
    end else if (strobes.shift) begin
      shReg <= {1'b1, shReg[FRAME_W-1:1]};
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) && wrEn && !strobes.load |=> (count == CNT_W'(DEPTH))); // R2

endmodule

// File: rtl/hs_uart_tx_control.sv
module hs_uart_tx_control
  import hs_uart_tx_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int OVERSAMPLE  = 14,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int OVS_W   = $clog2(OVERSAMPLE),
  localparam int FRAME_W = DATA_W + 2,
  localparam int BIT_W   = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divider,
  input  logic [CNT_W-1:0] count,
  input  logic             fifoEmpty,
  input  logic [1:0]       txTrig,
  input  logic             irqEn,
  input  logic             irqClr,
  input  logic             breakEn,
  input  logic             ctsEnable,
  input  logic             ctsInvert,
  input  logic             ctsIn,
  output txStrobes_t       strobes,
  output logic             busy,
  output logic             irqStatus,
  output logic             irqOut
);

  logic             ctsSynced;
  logic             ctsOk;
  logic             canStart;
  logic             bitEnd;
  logic             setIrq;
  logic [OVS_W-1:0] subCnt;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;

  // Clear-to-send synchronizer, depth chosen by parameter.
  generate
    if (SYNC_STAGES == 0) begin : gNoSync
      assign ctsSynced = ctsIn;
    end else begin : gSync
      logic [SYNC_STAGES-1:0] syncReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], ctsIn};
      end
      assign ctsSynced = syncReg[SYNC_STAGES-1];
    end
  endgenerate

  assign ctsOk    = !ctsEnable || (ctsSynced ^ ctsInvert);
  assign canStart = !busy && !fifoEmpty && !breakEn && ctsOk;
  assign bitEnd   = busy && (subCnt == OVS_W'(OVERSAMPLE - 1)) && (divCnt >= divider);

  always_comb begin
    strobes       = '0;
    strobes.load  = canStart;
    strobes.shift = bitEnd;
  end

  // Bit timing: subCnt runs 0..OVERSAMPLE-1, divCnt counts its wraps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      subCnt <= '0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (canStart) begin
      busy   <= 1'b1;
      subCnt <= '0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (subCnt == OVS_W'(OVERSAMPLE - 1)) begin
        subCnt <= '0;
        divCnt <= (divCnt >= divider) ? '0 : divCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
      if (bitEnd) begin
        if (bitCnt == BIT_W'(FRAME_W - 1)) begin
          busy   <= 1'b0;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // Low-water latch: set on a departure that leaves the queue at or under the mark.
  assign setIrq = canStart && ((int'(count) - 1) <= markOf(txTrig));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irqStatus <= 1'b0;
    else if (setIrq) irqStatus <= 1'b1;
    else if (irqClr) irqStatus <= 1'b0;
  end

  assign irqOut = irqStatus && irqEn;

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    irqClr && !strobes.load |=> !irqStatus); // R5
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus && !irqClr |=> irqStatus); // R4
  AST_BREAK_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    breakEn && !busy |=> !busy); // R7
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ctsEnable && !(ctsSynced ^ ctsInvert) && !busy |=> !busy); // R8
  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < BIT_W'(FRAME_W)); // R3

endmodule

// File: rtl/hs_uart_tx.sv
module hs_uart_tx
  import hs_uart_tx_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int LEVEL_W    = 8,
  parameter int OVERSAMPLE = 14,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DIV_W-1:0]   divider,
  input  logic [1:0]         txTrig,
  input  logic               irqEn,
  input  logic               irqClr,
  input  logic               breakEn,
  input  logic               ctsEnable,
  input  logic               ctsInvert,
  input  logic               ctsIn,
  output logic               txd,
  output logic [LEVEL_W-1:0] txLevel,
  output logic               irqStatus,
  output logic               irqOut
);

  txStrobes_t       strobes;
  logic [CNT_W-1:0] count;
  logic             fifoEmpty;
  logic             lineBit;
  logic             busy;

  hs_uart_tx_control #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .DIV_W(DIV_W), .OVERSAMPLE(OVERSAMPLE)
  ) u_control (
    .clk(clk), .rstN(rstN), .divider(divider), .count(count),
    .fifoEmpty(fifoEmpty), .txTrig(txTrig), .irqEn(irqEn), .irqClr(irqClr),
    .breakEn(breakEn), .ctsEnable(ctsEnable), .ctsInvert(ctsInvert),
    .ctsIn(ctsIn), .strobes(strobes), .busy(busy), .irqStatus(irqStatus),
    .irqOut(irqOut)
  );

  hs_uart_tx_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .strobes(strobes),
    .count(count), .fifoEmpty(fifoEmpty), .lineBit(lineBit)
  );

  assign txd     = breakEn ? 1'b0 : lineBit;
  assign txLevel = LEVEL_W'(count);

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !breakEn |-> txd); // R3

endmodule

// File: tb/hs_uart_tx_bench.sv
module hs_uart_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 14;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] divider = '0;
  logic [1:0] txTrig = '0;
  logic       irqEn = 1'b0;
  logic       irqClr = 1'b0;
  logic       breakEn = 1'b0;
  logic       ctsEnable = 1'b0;
  logic       ctsInvert = 1'b0;
  logic       ctsIn = 1'b0;
  logic       txd;
  logic [7:0] txLevel;
  logic       irqStatus;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] expQ[$];

  hs_uart_tx u_hs_uart_tx (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .divider(divider),
    .txTrig(txTrig), .irqEn(irqEn), .irqClr(irqClr), .breakEn(breakEn),
    .ctsEnable(ctsEnable), .ctsInvert(ctsInvert), .ctsIn(ctsIn), .txd(txd),
    .txLevel(txLevel), .irqStatus(irqStatus), .irqOut(irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int bitPeriod(input logic [7:0] d);
    return (int'(d) + 1) * OVS;
  endfunction

  function automatic int markFor(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (code == 2'd1) ? 4 : (code == 2'd2) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Mid-bit sampling receiver; returns the decoded byte.
  task automatic recvFrame(output logic [7:0] got, output bit ok);
    int p;
    int guard;
    p = bitPeriod(divider);
    got = '0;
    ok = 1'b1;
    guard = 0;
    while (txd !== 1'b0 && guard < 40 * p) begin
      @(negedge clk);
      guard++;
    end
    if (txd !== 1'b0) begin
      ok = 1'b0;
      return;
    end
    waitCycles(p / 2);
    if (txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      waitCycles(p);
      got[i] = txd;
    end
    waitCycles(p);
    if (txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic drainAndCompare(input int n, input string req);
    logic [7:0] got;
    bit ok;
    logic [7:0] exp;
    for (int i = 0; i < n; i++) begin
      recvFrame(got, ok);
      exp = expQ.pop_front();
      check(ok && got == exp, req, int'(got), int'(exp));
    end
  endtask

  task automatic waitLevel(input int lvl);
    int guard;
    guard = 0;
    while (int'(txLevel) != lvl && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic clearIrq();
    @(negedge clk);
    irqClr = 1'b1;
    @(negedge clk);
    irqClr = 1'b0;
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] got;
    bit ok;
    void'($urandom(32'h1A2B3C4D));

    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    // R9: reset state
    check(txd === 1'b1, "R9 txd", int'(txd), 1);
    check(txLevel === 8'd0, "R9 level", int'(txLevel), 0);
    check(irqStatus === 1'b0 && irqOut === 1'b0, "R9 irq", int'(irqStatus), 0);

    // R3: random bytes at several dividers
    for (int d = 0; d < 3; d++) begin
      divider = 8'(d);
      for (int i = 0; i < 4; i++) begin
        b = 8'($urandom);
        expQ.push_back(b);
        pushByte(b);
      end
      drainAndCompare(4, "R3 frame");
      waitCycles(bitPeriod(divider));
      check(txd === 1'b1, "R3 idle high", int'(txd), 1);
    end
    divider = 8'd0;

    // R1/R2: fill while clear-to-send holds the line, then overflow
    ctsEnable = 1'b1;
    ctsInvert = 1'b0;
    ctsIn = 1'b0;
    waitCycles(4);
    for (int i = 0; i < 64; i++) begin
      b = 8'($urandom);
      expQ.push_back(b);
      pushByte(b);
    end
    check(txLevel == 8'd64, "R1 level after 64 writes", int'(txLevel), 64);
    check(txd === 1'b1, "R8 held while inactive", int'(txd), 1);
    pushByte(8'hEE);
    check(txLevel == 8'd64, "R2 overflow dropped", int'(txLevel), 64);
    ctsIn = 1'b1;
    drainAndCompare(64, "R2 order after overflow");
    waitCycles(12 * OVS);
    check(txLevel == 8'd0 && txd === 1'b1, "R2 extra byte absent", int'(txLevel), 0);

    // R4/R5/R6: low-water mark for each code
    for (int c = 0; c < 4; c++) begin
      int mark;
      txTrig = 2'(c);
      mark = markFor(2'(c));
      ctsIn = 1'b0;
      waitCycles(4);
      for (int i = 0; i < mark + 2; i++) pushByte(8'($urandom));
      clearIrq();
      check(irqStatus === 1'b0, "R5 cleared", int'(irqStatus), 0);
      ctsIn = 1'b1;
      waitLevel(mark + 1);
      @(negedge clk);
      check(irqStatus === 1'b0, "R4 above mark", int'(irqStatus), 0);
      waitLevel(mark);
      @(negedge clk);
      check(irqStatus === 1'b1, "R4 at mark", int'(irqStatus), 1);
      check(irqOut === 1'b0, "R6 masked", int'(irqOut), 0);
      irqEn = 1'b1;
      @(negedge clk);
      check(irqOut === 1'b1, "R6 enabled", int'(irqOut), 1);
      irqEn = 1'b0;
      clearIrq();
      check(irqStatus === 1'b0, "R5 clear at mark", int'(irqStatus), 0);
      if (mark > 0) begin
        waitLevel(mark - 1);
        @(negedge clk);
        check(irqStatus === 1'b1, "R4 set again below mark", int'(irqStatus), 1);
      end
      waitLevel(0);
      waitCycles(12 * OVS);
    end
    ctsEnable = 1'b0;

    // R7: break holds the line and the queue
    breakEn = 1'b1;
    for (int i = 0; i < 3; i++) begin
      b = 8'($urandom);
      expQ.push_back(b);
      pushByte(b);
    end
    begin
      bit allLow;
      allLow = 1'b1;
      for (int i = 0; i < 20 * OVS; i++) begin
        @(negedge clk);
        if (txd !== 1'b0) allLow = 1'b0;
      end
      check(allLow, "R7 line low", int'(txd), 0);
    end
    check(txLevel == 8'd3, "R7 queue kept", int'(txLevel), 3);
    breakEn = 1'b0;
    drainAndCompare(3, "R7 bytes after break");

    // R8: inverted polarity and a drop in the middle of a frame
    ctsEnable = 1'b1;
    ctsInvert = 1'b1;
    ctsIn = 1'b1;
    waitCycles(4);
    expQ.push_back(8'hA5);
    expQ.push_back(8'h3C);
    pushByte(8'hA5);
    pushByte(8'h3C);
    waitCycles(12 * OVS);
    check(txLevel == 8'd2 && txd === 1'b1, "R8 inverted inactive", int'(txLevel), 2);
    ctsIn = 1'b0;
    fork
      begin
        recvFrame(got, ok);
        b = expQ.pop_front();
        check(ok && got == b, "R8 frame completes", int'(got), int'(b));
      end
      begin
        waitCycles(3 * OVS);
        ctsIn = 1'b1;
      end
    join
    waitCycles(12 * OVS);
    check(txLevel == 8'd1 && txd === 1'b1, "R8 next held", int'(txLevel), 1);
    ctsIn = 1'b0;
    drainAndCompare(1, "R8 resumes");
    ctsEnable = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule